// File: doc/BRIEF.md
# Dual-Mode Command Front-End

This block sits in front of a 64-bit-wide associative memory and turns two different control sources into one internal command stream. In hardware mode, dedicated pins drive each cycle directly: a 9-bit control bus, a half-word select, an active-low write strobe, an address-valid line and an active-low validity line. A cycle with address-valid low is a random read or write of one location. A cycle with address-valid high carries an opcode and a mask-register select.

In software mode the control pins are idle. Instructions are written over the 32-bit data bus into an instruction register. An instruction that does not move data runs in the cycle in which it is loaded. An instruction that moves data is only stored. It then runs on every later data cycle until another instruction replaces it. A read cycle with address-valid high returns a status image at once. Every executed operation gives a one-cycle command pulse that is registered one cycle after the sampling edge. A small store models the memory locations, their valid bits and a 64-bit scratch register so that data movement can be seen at the ports.

Top module: `cmd_frontend`

## Requirements
- R1: After synchronous reset, all outputs are idle (cmd_valid, dq_oe, vld_oe and sr_sel are 0), the block is in hardware mode, the instruction register holds 0 (a no-operation that moves no data) and every location reads as empty (vld_n_out = 1).
- R2: A configuration write selects software mode only when both mode bits are 1. Any other value (00, 01, 10) selects hardware mode.
- R3: In hardware mode, a cycle with av_n = 0 and wr_n = 0 stores dq_in into the 32-bit half chosen by half (0 = bits 31-0, 1 = bits 63-32) of location ctl[AW-1:0], and stores vld_n_in as that location's valid bit. The next cycle shows cmd_kind = 1 (random), cmd_rd = 0, the address, the half and cmd_vld_n = vld_n_in.
- R4: In hardware mode, a cycle with av_n = 0 and wr_n = 1 drives the addressed half onto dq_out and the stored valid bit onto vld_n_out (0 = valid, 1 = empty) in the next cycle, with dq_oe = vld_oe = 1. The command shows cmd_kind = 1, cmd_rd = 1 and cmd_vld_n equal to the stored bit.
- R5: In hardware mode, a cycle with av_n = 1 gives cmd_kind = 2 (control), cmd_op = ctl[5:0], cmd_mask = ctl[8:6], cmd_half = half, cmd_rd = wr_n and cmd_addr = 0.
- R6: In software mode, a cycle with av_n = 1 and wr_n = 0 loads the instruction register from dq_in. The opcode comes from bits 5-0, the mask select from bits 8-6, the half from bit 12 and the read flag from bit 13 (0 = write variant, 1 = read variant). All other data bits are ignored.
- R7: A loaded instruction with opcode bit 5 = 0 runs at once. The next cycle shows cmd_kind = 2 with the loaded fields.
- R8: A loaded instruction with opcode bit 5 = 1 gives no command when it is loaded. Every later software-mode cycle with av_n = 0 gives cmd_kind = 3 (deferred data) with the stored fields, until a new instruction is loaded.
- R9: A deferred data cycle with read flag 0 writes dq_in into the selected half of the scratch register. With read flag 1 it drives that half onto dq_out with dq_oe = 1.
- R10: In software mode, a cycle with av_n = 1 and wr_n = 1 drives the status image onto dq_out in the next cycle. The image is 0 except for bit 13 = read flag, bit 12 = half, bits 8-6 = mask and bits 5-0 = opcode of the instruction register. It also sets sr_sel = 1 and gives no command.
- R11: cmd_valid is high for exactly one cycle per executed operation, one cycle after the sampling edge. A cycle with cyc = 0 leaves all outputs idle in the next cycle.
- R12: In software mode, a data cycle (av_n = 0) while the instruction register holds an opcode with bit 5 = 0 is ignored: no command and dq_oe = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode bits; 11 selects software mode |
| cyc | input | 1 | Qualifies a bus cycle at this edge |
| ctl | input | 9 | Control bus: location address, or mask select and opcode |
| half | input | 1 | Half-word select (0 = low 32 bits, 1 = high 32 bits) |
| wr_n | input | 1 | Active-low write strobe |
| av_n | input | 1 | Low = address/data cycle, high = control cycle |
| vld_n_in | input | 1 | Active-low validity written by a random write |
| dq_in | input | 32 | Data bus input |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_kind | output | 2 | 0 none, 1 random, 2 control, 3 deferred data |
| cmd_op | output | 6 | Command opcode |
| cmd_mask | output | 3 | Mask register select |
| cmd_half | output | 1 | Half-word select of the command |
| cmd_rd | output | 1 | 1 = read variant, 0 = write variant |
| cmd_addr | output | AW | Location of a random access, else 0 |
| cmd_vld_n | output | 1 | Validity written or read by a random access, else 1 |
| dq_out | output | 32 | Read data or status image |
| dq_oe | output | 1 | dq_out is driven |
| vld_n_out | output | 1 | Validity of the location read |
| vld_oe | output | 1 | vld_n_out is driven |
| sr_sel | output | 1 | dq_out carries the status image |

## Verification
The assertions assume that a configuration write never falls in the same cycle as a qualified bus cycle. They also assume that each input is steady around the rising edge at which it is sampled. The bench drives every input on the falling edge and raises cfg_wr and cyc in separate cycles. Each cycle is followed by an idle cycle, so mode changes and command pulses never overlap. Reset is applied again in the middle of the run, only while no cycle is qualified.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;

    localparam int OP_W       = 6;
    localparam int MSK_W      = 3;
    localparam int CTL_W      = 9;
    localparam int DQ_W       = 32;
    localparam int WORD_W     = 2 * DQ_W;
    localparam int LD_HALF_B  = 12;
    localparam int LD_RD_B    = 13;
    localparam int DATA_OP_B  = OP_W - 1;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_RAND = 2'd1,
        K_CTRL = 2'd2,
        K_DATA = 2'd3
    } kind_e;

    typedef struct packed {
        logic             rd;
        logic             half;
        logic [MSK_W-1:0] mask;
        logic [OP_W-1:0]  op;
    } instr_t;

    typedef struct packed {
        kind_e  kind;
        instr_t f;
    } cmd_t;

    localparam instr_t INSTR_NOP = '{rd: 1'b0, half: 1'b0, mask: '0, op: '0};
    localparam cmd_t   CMD_IDLE  = '{kind: K_NONE, f: INSTR_NOP};

    function automatic logic [DQ_W-1:0] status_word(input instr_t ir);
        logic [DQ_W-1:0] w;
        w = '0;
        w[OP_W-1:0]            = ir.op;
        w[OP_W+MSK_W-1:OP_W]   = ir.mask;
        w[LD_HALF_B]           = ir.half;
        w[LD_RD_B]             = ir.rd;
        return w;
    endfunction

endpackage

// File: rtl/cmdfe_hw_dec.sv
module cmdfe_hw_dec
    import cmdfe_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [CTL_W-1:0] ctl,
    input  logic             half,
    input  logic             wr_n,
    input  logic             av_n,
    output cmd_t             cmd,
    output logic [AW-1:0]    addr
);

    always_comb begin
        cmd        = CMD_IDLE;
        addr       = '0;
        cmd.f.half = half;
        cmd.f.rd   = wr_n;
        if (!av_n) begin
            cmd.kind = K_RAND;
            addr     = ctl[AW-1:0];
        end else begin
            cmd.kind   = K_CTRL;
            cmd.f.op   = ctl[OP_W-1:0];
            cmd.f.mask = ctl[OP_W+MSK_W-1:OP_W];
        end
    end

endmodule

// File: rtl/cmdfe_sw_seq.sv
module cmdfe_sw_seq
    import cmdfe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  av_n,
    input  logic                  wr_n,
    input  logic [OP_W+MSK_W-1:0] ld_code,
    input  logic                  ld_half,
    input  logic                  ld_rd,
    output cmd_t                  cmd,
    output instr_t                ir,
    output logic                  sr_rd
);

    instr_t ld;
    logic   load;

    always_comb begin
        ld.op   = ld_code[OP_W-1:0];
        ld.mask = ld_code[OP_W+MSK_W-1:OP_W];
        ld.half = ld_half;
        ld.rd   = ld_rd;
        load    = en && av_n && !wr_n;
        sr_rd   = en && av_n && wr_n;
        cmd     = CMD_IDLE;
        if (load && !ld.op[DATA_OP_B]) begin
            cmd.kind = K_CTRL;
            cmd.f    = ld;
        end else if (en && !av_n && ir.op[DATA_OP_B]) begin
            cmd.kind = K_DATA;
            cmd.f    = ir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir <= INSTR_NOP;
        end else if (load) begin
            ir <= ld;
        end
    end

endmodule

// File: rtl/cmdfe_store.sv
module cmdfe_store
    import cmdfe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mem_we,
    input  logic [AW-1:0]   addr,
    input  logic            mem_half,
    input  logic [DQ_W-1:0] wdata,
    input  logic            vld_n_w,
    input  logic            scr_we,
    input  logic            scr_half,
    output logic [DQ_W-1:0] mem_rdata,
    output logic            vld_n_r,
    output logic [DQ_W-1:0] scr_rdata
);

    logic [WORD_W-1:0] mem  [DEPTH];
    logic              vbit [DEPTH];
    logic [WORD_W-1:0] scr;

    always_ff @(posedge clk) begin
        if (mem_we) begin
            if (mem_half) mem[addr][WORD_W-1:DQ_W] <= wdata;
            else          mem[addr][DQ_W-1:0]      <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) vbit[i] <= 1'b1;
        end else if (mem_we) begin
            vbit[addr] <= vld_n_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scr <= '0;
        end else if (scr_we) begin
            if (scr_half) scr[WORD_W-1:DQ_W] <= wdata;
            else          scr[DQ_W-1:0]      <= wdata;
        end
    end

    assign mem_rdata = mem_half ? mem[addr][WORD_W-1:DQ_W] : mem[addr][DQ_W-1:0];
    assign vld_n_r   = vbit[addr];
    assign scr_rdata = scr_half ? scr[WORD_W-1:DQ_W] : scr[DQ_W-1:0];

endmodule

// File: rtl/cmd_frontend.sv
module cmd_frontend
    import cmdfe_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_mode,
    input  logic                 cyc,
    input  logic [CTL_W-1:0]     ctl,
    input  logic                 half,
    input  logic                 wr_n,
    input  logic                 av_n,
    input  logic                 vld_n_in,
    input  logic [DQ_W-1:0]      dq_in,
    output logic                 cmd_valid,
    output logic [1:0]           cmd_kind,
    output logic [OP_W-1:0]      cmd_op,
    output logic [MSK_W-1:0]     cmd_mask,
    output logic                 cmd_half,
    output logic                 cmd_rd,
    output logic [AW-1:0]        cmd_addr,
    output logic                 cmd_vld_n,
    output logic [DQ_W-1:0]      dq_out,
    output logic                 dq_oe,
    output logic                 vld_n_out,
    output logic                 vld_oe,
    output logic                 sr_sel
);

    logic            mode_sw;
    logic            hw_en, sw_en;
    cmd_t            hw_cmd, sw_cmd, sel_cmd, cmd_q;
    logic [AW-1:0]   hw_addr;
    instr_t          ir;
    logic            sr_rd;
    logic            mem_we, mem_re, scr_we, scr_re;
    logic [DQ_W-1:0] mem_rdata, scr_rdata;
    logic            vld_n_r;

    always_ff @(posedge clk) begin
        if (rst)         mode_sw <= 1'b0;
        else if (cfg_wr) mode_sw <= &cfg_mode;
    end

    assign hw_en = cyc && !mode_sw;
    assign sw_en = cyc && mode_sw;

    cmdfe_hw_dec #(.AW(AW)) u_hw (
        .ctl  (ctl),
        .half (half),
        .wr_n (wr_n),
        .av_n (av_n),
        .cmd  (hw_cmd),
        .addr (hw_addr)
    );

    cmdfe_sw_seq u_sw (
        .clk     (clk),
        .rst     (rst),
        .en      (sw_en),
        .av_n    (av_n),
        .wr_n    (wr_n),
        .ld_code (dq_in[OP_W+MSK_W-1:0]),
        .ld_half (dq_in[LD_HALF_B]),
        .ld_rd   (dq_in[LD_RD_B]),
        .cmd     (sw_cmd),
        .ir      (ir),
        .sr_rd   (sr_rd)
    );

    assign mem_we = hw_en && !av_n && !wr_n;
    assign mem_re = hw_en && !av_n && wr_n;
    assign scr_we = (sw_cmd.kind == K_DATA) && !sw_cmd.f.rd;
    assign scr_re = (sw_cmd.kind == K_DATA) && sw_cmd.f.rd;

    cmdfe_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .mem_we    (mem_we),
        .addr      (hw_addr),
        .mem_half  (half),
        .wdata     (dq_in),
        .vld_n_w   (vld_n_in),
        .scr_we    (scr_we),
        .scr_half  (sw_cmd.f.half),
        .mem_rdata (mem_rdata),
        .vld_n_r   (vld_n_r),
        .scr_rdata (scr_rdata)
    );

    always_comb begin
        if (hw_en)      sel_cmd = hw_cmd;
        else if (sw_en) sel_cmd = sw_cmd;
        else            sel_cmd = CMD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= CMD_IDLE;
            cmd_addr  <= '0;
            cmd_vld_n <= 1'b1;
            dq_out    <= '0;
            dq_oe     <= 1'b0;
            vld_n_out <= 1'b1;
            vld_oe    <= 1'b0;
            sr_sel    <= 1'b0;
        end else begin
            cmd_q     <= sel_cmd;
            cmd_addr  <= (hw_en && !av_n) ? hw_addr : '0;
            cmd_vld_n <= mem_we ? vld_n_in : (mem_re ? vld_n_r : 1'b1);
            dq_oe     <= mem_re || scr_re || sr_rd;
            if (mem_re)      dq_out <= mem_rdata;
            else if (scr_re) dq_out <= scr_rdata;
            else if (sr_rd)  dq_out <= status_word(ir);
            else             dq_out <= '0;
            vld_oe    <= mem_re;
            vld_n_out <= mem_re ? vld_n_r : 1'b1;
            sr_sel    <= sr_rd;
        end
    end

    assign cmd_valid = (cmd_q.kind != K_NONE);
    assign cmd_kind  = cmd_q.kind;
    assign cmd_op    = cmd_q.f.op;
    assign cmd_mask  = cmd_q.f.mask;
    assign cmd_half  = cmd_q.f.half;
    assign cmd_rd    = cmd_q.f.rd;

endmodule

// File: rtl/cmdfe_chk.sv
module cmdfe_chk (
    input logic       clk,
    input logic       rst,
    input logic       cyc,
    input logic       av_n,
    input logic       wr_n,
    input logic       vld_n_in,
    input logic       dq_bit5,
    input logic       mode_sw,
    input logic       ir_data_op,
    input logic       cmd_valid,
    input logic [1:0] cmd_kind,
    input logic       cmd_rd,
    input logic       cmd_vld_n,
    input logic       dq_oe,
    input logic       vld_oe,
    input logic       sr_sel
);

    a_r11_cmd_after_cyc: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(cyc));

    a_r4_vld_with_data: assert property (@(posedge clk) disable iff (rst)
        vld_oe |-> dq_oe);

    a_r10_status_alone: assert property (@(posedge clk) disable iff (rst)
        sr_sel |-> (!cmd_valid && dq_oe));

    a_r8_deferred_silent: assert property (@(posedge clk) disable iff (rst)
        (cyc && mode_sw && av_n && !wr_n && dq_bit5) |=> !cmd_valid);

    a_r3_write_echo: assert property (@(posedge clk) disable iff (rst)
        (cyc && !mode_sw && !av_n && !wr_n) |=>
            (cmd_valid && cmd_kind == 2'd1 && !cmd_rd && cmd_vld_n == $past(vld_n_in)));

    a_r12_unarmed_idle: assert property (@(posedge clk) disable iff (rst)
        (cyc && mode_sw && !av_n && !ir_data_op) |=> (!cmd_valid && !dq_oe));

endmodule

bind cmd_frontend cmdfe_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc        (cyc),
    .av_n       (av_n),
    .wr_n       (wr_n),
    .vld_n_in   (vld_n_in),
    .dq_bit5    (dq_in[5]),
    .mode_sw    (mode_sw),
    .ir_data_op (ir.op[5]),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_rd     (cmd_rd),
    .cmd_vld_n  (cmd_vld_n),
    .dq_oe      (dq_oe),
    .vld_oe     (vld_oe),
    .sr_sel     (sr_sel)
);

// File: tb/cmd_frontend_tb.sv
module cmd_frontend_tb;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cyc = 1'b0;
    logic [8:0]  ctl = '0;
    logic        half = 1'b0;
    logic        wr_n = 1'b1;
    logic        av_n = 1'b1;
    logic        vld_n_in = 1'b1;
    logic [31:0] dq_in = '0;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [5:0]  cmd_op;
    logic [2:0]  cmd_mask;
    logic        cmd_half;
    logic        cmd_rd;
    logic [AW-1:0] cmd_addr;
    logic        cmd_vld_n;
    logic [31:0] dq_out;
    logic        dq_oe;
    logic        vld_n_out;
    logic        vld_oe;
    logic        sr_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmd_frontend #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cyc(cyc),
        .ctl(ctl), .half(half), .wr_n(wr_n), .av_n(av_n), .vld_n_in(vld_n_in),
        .dq_in(dq_in), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_op(cmd_op),
        .cmd_mask(cmd_mask), .cmd_half(cmd_half), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
        .cmd_vld_n(cmd_vld_n), .dq_out(dq_out), .dq_oe(dq_oe), .vld_n_out(vld_n_out),
        .vld_oe(vld_oe), .sr_sel(sr_sel)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // packed view of the command: valid, kind, rd, half, mask, op, addr, vld_n
    function automatic logic [63:0] cmd_view();
        return {44'd0, cmd_valid, cmd_kind, cmd_rd, cmd_half, cmd_mask, cmd_op, cmd_addr, cmd_vld_n};
    endfunction

    function automatic logic [63:0] cmd_exp(input logic v, input logic [1:0] k, input logic r,
                                            input logic h, input logic [2:0] m, input logic [5:0] o,
                                            input logic [AW-1:0] a, input logic vn);
        return {44'd0, v, k, r, h, m, o, a, vn};
    endfunction

    function automatic logic [63:0] port_view();
        return {28'd0, dq_out, dq_oe, vld_n_out, vld_oe, sr_sel};
    endfunction

    function automatic logic [63:0] port_exp(input logic [31:0] d, input logic oe,
                                             input logic vn, input logic voe, input logic s);
        return {28'd0, d, oe, vn, voe, s};
    endfunction

    // one qualified cycle, then back to idle; outputs are sampled on return
    task automatic bus(input logic a_n, input logic w_n, input logic h,
                       input logic [8:0] c, input logic vn, input logic [31:0] d);
        @(negedge clk);
        cyc = 1'b1; av_n = a_n; wr_n = w_n; half = h; ctl = c; vld_n_in = vn; dq_in = d;
        @(negedge clk);
        cyc = 1'b0; wr_n = 1'b1; av_n = 1'b1;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = m;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [31:0] load_word(input logic r, input logic h,
                                              input logic [2:0] m, input logic [5:0] o);
        return {18'd0, r, h, 3'd0, m, o};
    endfunction

    function automatic logic [31:0] pat(input int a, input int h);
        return {16'hC300 + 16'(a), 8'(a * 7 + h), (h != 0) ? 8'h5A : 8'h3C};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1 reset outputs", port_view(), port_exp(32'd0, 1'b0, 1'b1, 1'b0, 1'b0));
        chk("R1 reset cmd", {63'd0, cmd_valid}, 64'd0);

        // R1: starts in hardware mode, control cycle decodes (R5)
        bus(1'b1, 1'b1, 1'b0, 9'h1C5, 1'b1, 32'd0);
        chk("R1 hw mode after reset", cmd_view(),
            cmd_exp(1'b1, 2'd2, 1'b1, 1'b0, 3'd7, 6'h05, '0, 1'b1));
        chk("R1 hw mode no status", {63'd0, sr_sel}, 64'd0);

        // R11: idle cycle gives no command
        @(negedge clk);
        chk("R11 single pulse", {62'd0, cmd_valid, dq_oe}, 64'd0);

        // R1/R4: location empty after reset
        bus(1'b0, 1'b1, 1'b0, 9'd3, 1'b0, 32'd0);
        chk("R1 R4 empty after reset", {63'd0, vld_n_out}, 64'd1);

        // R3: write sweep over every location and half
        for (int a = 0; a < DEPTH; a++) begin
            for (int h = 0; h < 2; h++) begin
                bus(1'b0, 1'b0, 1'(h), 9'(a), 1'(a % 2), pat(a, h));
                chk("R3 write echo", cmd_view(),
                    cmd_exp(1'b1, 2'd1, 1'b0, 1'(h), 3'd0, 6'd0, AW'(a), 1'(a % 2)));
            end
        end

        // R4: read back sweep
        for (int a = 0; a < DEPTH; a++) begin
            for (int h = 0; h < 2; h++) begin
                bus(1'b0, 1'b1, 1'(h), 9'(a), 1'b1, 32'hFFFF_FFFF);
                chk("R4 read data", port_view(), port_exp(pat(a, h), 1'b1, 1'(a % 2), 1'b1, 1'b0));
                chk("R4 read cmd", cmd_view(),
                    cmd_exp(1'b1, 2'd1, 1'b1, 1'(h), 3'd0, 6'd0, AW'(a), 1'(a % 2)));
            end
        end

        // R5: control decode sweep
        for (int i = 0; i < 64; i++) begin
            logic [8:0] c;
            c = 9'(i * 37 + 5);
            bus(1'b1, 1'(i % 2), 1'((i / 2) % 2), c, 1'b1, 32'd0);
            chk("R5 control decode", cmd_view(),
                cmd_exp(1'b1, 2'd2, 1'(i % 2), 1'((i / 2) % 2), c[8:6], c[5:0], '0, 1'b1));
        end

        // R2: mixed mode bits keep hardware mode
        set_mode(2'b01);
        bus(1'b1, 1'b1, 1'b0, 9'h0AA, 1'b1, 32'd0);
        chk("R2 mode 01 is hardware", {62'd0, cmd_valid, sr_sel}, 64'd2);
        set_mode(2'b10);
        bus(1'b1, 1'b1, 1'b0, 9'h0AA, 1'b1, 32'd0);
        chk("R2 mode 10 is hardware", {62'd0, cmd_valid, sr_sel}, 64'd2);
        set_mode(2'b11);

        // R10/R1: status reads the cleared instruction register
        bus(1'b1, 1'b1, 1'b0, 9'd0, 1'b1, 32'd0);
        chk("R10 R1 status after reset", port_view(), port_exp(32'd0, 1'b1, 1'b1, 1'b0, 1'b1));
        chk("R10 no command", {63'd0, cmd_valid}, 64'd0);

        // R12: data cycle with no-op loaded is ignored
        bus(1'b0, 1'b0, 1'b0, 9'd0, 1'b1, 32'h1111_2222);
        chk("R12 unarmed data cycle", {62'd0, cmd_valid, dq_oe}, 64'd0);

        // R6 R7 R10: immediate loads with noise in unused bits
        for (int i = 0; i < 32; i++) begin
            logic [31:0] w;
            w = load_word(1'((i / 8) % 2), 1'((i / 4) % 2), 3'(i % 8), 6'(i));
            bus(1'b1, 1'b0, 1'b0, 9'h1FF, 1'b1, w | 32'hA5A4_0E00);
            chk("R7 R6 immediate command", cmd_view(),
                cmd_exp(1'b1, 2'd2, 1'((i / 8) % 2), 1'((i / 4) % 2), 3'(i % 8), 6'(i), '0, 1'b1));
            bus(1'b1, 1'b1, 1'b0, 9'd0, 1'b1, 32'd0);
            chk("R10 R6 status image", port_view(), port_exp(w, 1'b1, 1'b1, 1'b0, 1'b1));
        end

        // R8 R9: deferred write to high half, persistent
        bus(1'b1, 1'b0, 1'b0, 9'd0, 1'b1, load_word(1'b0, 1'b1, 3'd5, 6'h21));
        chk("R8 load is silent", {63'd0, cmd_valid}, 64'd0);
        bus(1'b0, 1'b0, 1'b0, 9'd0, 1'b1, 32'hDEAD_BEEF);
        chk("R8 deferred exec", cmd_view(),
            cmd_exp(1'b1, 2'd3, 1'b0, 1'b1, 3'd5, 6'h21, '0, 1'b1));
        bus(1'b0, 1'b1, 1'b0, 9'd0, 1'b1, 32'h1234_5678);
        chk("R8 persistent exec", cmd_view(),
            cmd_exp(1'b1, 2'd3, 1'b0, 1'b1, 3'd5, 6'h21, '0, 1'b1));
        chk("R9 write drives nothing", {63'd0, dq_oe}, 64'd0);

        // R9: deferred reads
        bus(1'b1, 1'b0, 1'b0, 9'd0, 1'b1, load_word(1'b1, 1'b1, 3'd2, 6'h3F));
        chk("R8 read load silent", {63'd0, cmd_valid}, 64'd0);
        bus(1'b0, 1'b0, 1'b0, 9'd0, 1'b1, 32'd0);
        chk("R9 read high half", port_view(), port_exp(32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b0));
        chk("R9 read cmd", cmd_view(), cmd_exp(1'b1, 2'd3, 1'b1, 1'b1, 3'd2, 6'h3F, '0, 1'b1));
        bus(1'b1, 1'b0, 1'b0, 9'd0, 1'b1, load_word(1'b1, 1'b0, 3'd0, 6'h30));
        bus(1'b0, 1'b1, 1'b0, 9'd0, 1'b1, 32'd0);
        chk("R9 low half still reset", port_view(), port_exp(32'd0, 1'b1, 1'b1, 1'b0, 1'b0));
        bus(1'b1, 1'b0, 1'b0, 9'd0, 1'b1, load_word(1'b0, 1'b0, 3'd1, 6'h22));
        bus(1'b0, 1'b1, 1'b0, 9'd0, 1'b1, 32'hCAFE_F00D);
        bus(1'b1, 1'b0, 1'b0, 9'd0, 1'b1, load_word(1'b1, 1'b0, 3'd1, 6'h22));
        bus(1'b0, 1'b0, 1'b0, 9'd0, 1'b1, 32'd0);
        chk("R9 low half written", port_view(), port_exp(32'hCAFE_F00D, 1'b1, 1'b1, 1'b0, 1'b0));

        // R10: status while a deferred read is armed
        bus(1'b1, 1'b1, 1'b0, 9'd0, 1'b1, 32'd0);
        chk("R10 armed status", port_view(),
            port_exp(load_word(1'b1, 1'b0, 3'd1, 6'h22), 1'b1, 1'b1, 1'b0, 1'b1));

        // R11: no qualified cycle, no command
        @(negedge clk);
        av_n = 1'b0;
        @(negedge clk);
        chk("R11 cyc low idle", {62'd0, cmd_valid, dq_oe}, 64'd0);
        av_n = 1'b1;

        // R1: reset drops the armed instruction and returns to hardware mode
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus(1'b1, 1'b1, 1'b0, 9'h041, 1'b1, 32'd0);
        chk("R1 reset to hw mode", cmd_view(),
            cmd_exp(1'b1, 2'd2, 1'b1, 1'b0, 3'd1, 6'h01, '0, 1'b1));
        set_mode(2'b11);
        bus(1'b0, 1'b0, 1'b0, 9'd0, 1'b1, 32'd0);
        chk("R1 R12 armed dropped", {62'd0, cmd_valid, dq_oe}, 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule